// File: doc/BRIEF.md
# Precision time-of-day counter

This block keeps a free-running time of day in a seconds-plus-nanoseconds format for precision time protocol work. It runs on a timestamp clock. On every cycle it adds a programmable whole-nanosecond step to the nanoseconds count. It also adds a programmable 16-bit sub-nanosecond fraction to a private accumulator, and each overflow of that accumulator adds one extra nanosecond. When the nanoseconds reach one billion they wrap, and the 48-bit seconds count goes up by one. The seconds are kept as a 16-bit upper word and a 32-bit lower word.

Host software reaches the block through a plain address/data register port. Setting the nominal step to one billion divided by the clock rate, with the remainder scaled by 2^16 as the fraction, gives a clock that runs at the nominal rate. Writing slightly larger or smaller step values trims the frequency. The time is set one word at a time, and no word write is staged for the others. A one-shot signed offset write slews the phase. Reading the lower seconds word freezes a copy of the upper seconds and the nanoseconds, so that a three-read sequence returns one consistent time.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds, step, fraction and accumulator are all zero. With a zero step and a zero fraction, the time does not move.
- R2: On each cycle the nanoseconds grow by the step register plus one if the 16-bit accumulator plus the fraction register overflows 16 bits. The accumulator keeps the low 16 bits of that sum.
- R3: The nanoseconds value always stays below 1,000,000,000. When a sum reaches that value, it is reduced by 1,000,000,000 per whole second, and the 48-bit seconds grow by the same count, with carry from the lower word into the upper word.
- R4: Register map: address 0 holds the step (bits 7:0), 1 the fraction (bits 15:0), 2 the upper seconds (bits 15:0), 3 the lower seconds, 4 the nanoseconds (bits 29:0) and 5 the offset. A write to address 2, 3 or 4 replaces only that word, and the other words keep counting.
- R5: A write to the nanoseconds register sets the accumulator to zero.
- R6: A new step or fraction value written at a clock edge is used from the next edge onward, and the accumulator keeps its contents.
- R7: An offset write holds a sign in bit 31 (1 = subtract) and a magnitude in nanoseconds in bits 29:0. The offset is applied once, at the edge after the write, on top of that cycle's normal advance, with carry or borrow of up to two seconds.
- R8: An offset write with a zero magnitude leaves the time unchanged, whatever the sign bit.
- R9: A read at address 3 returns the live lower seconds. At that same edge it copies the upper seconds and the nanoseconds into shadow registers. Addresses 2 and 4 read back those shadow values, which hold until the next read at address 3.
- R10: Addresses 0 and 1 read back the step and fraction that were last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; needed only for the snapshot at address 3 |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |

## Verification
Errors in the per-cycle arithmetic build up. A lost fraction carry, or an accumulator that is not cleared, puts the read-out nanoseconds off by one or more after only a few cycles. The bench compares every snapshot with a time it works out from the elapsed cycle count and the step history. A wrong wrap or borrow shows up at the first snapshot taken after a seconds boundary, as a seconds word off by one or two. A snapshot taken at the wrong moment shows up as a lower seconds word and shadow nanoseconds that do not add up to the expected time.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int INC_W      = 8,
  parameter int FRAC_W     = 16,
  parameter int SECH_W     = 16,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int SW  = NS_W + 4;
  localparam int SEC_W = SECH_W + 32;
  localparam logic signed [SW-1:0] ONE_S = SW'(NS_PER_SEC);
  localparam logic signed [SW-1:0] TWO_S = SW'(2 * NS_PER_SEC);

  localparam logic [2:0] A_STEP = 3'd0, A_FRAC = 3'd1, A_SECH = 3'd2,
                         A_SECL = 3'd3, A_NS = 3'd4, A_ADJ = 3'd5;

  logic [INC_W-1:0]  inc_q;
  logic [FRAC_W-1:0] frac_q, acc_q;
  logic [NS_W-1:0]   ns_q, sh_ns, adj_mag;
  logic [SECH_W-1:0] sech_q, sh_sech;
  logic [31:0]       secl_q;
  logic              adj_pend, adj_neg;

  logic [FRAC_W:0]        acc_sum;
  logic signed [SW-1:0]   t_base, t_sum, t_norm;
  logic signed [2:0]      dsec;
  logic [SEC_W-1:0]       sec_n;

  wire w_step = wr_en && addr == A_STEP;
  wire w_frac = wr_en && addr == A_FRAC;
  wire w_sech = wr_en && addr == A_SECH;
  wire w_secl = wr_en && addr == A_SECL;
  wire w_ns   = wr_en && addr == A_NS;
  wire w_adj  = wr_en && addr == A_ADJ;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};
  assign t_base  = signed'({{(SW-NS_W){1'b0}}, ns_q})
                 + signed'({{(SW-INC_W){1'b0}}, inc_q})
                 + signed'({{(SW-1){1'b0}}, acc_sum[FRAC_W]});
  assign t_sum   = !adj_pend ? t_base
                 : adj_neg   ? t_base - signed'({{(SW-NS_W){1'b0}}, adj_mag})
                             : t_base + signed'({{(SW-NS_W){1'b0}}, adj_mag});

  always_comb begin
    if (t_sum >= TWO_S) begin
      t_norm = t_sum - TWO_S; dsec = 3'sd2;
    end else if (t_sum >= ONE_S) begin
      t_norm = t_sum - ONE_S; dsec = 3'sd1;
    end else if (t_sum >= 0) begin
      t_norm = t_sum;         dsec = 3'sd0;
    end else if (t_sum >= -ONE_S) begin
      t_norm = t_sum + ONE_S; dsec = -3'sd1;
    end else begin
      t_norm = t_sum + TWO_S; dsec = -3'sd2;
    end
  end

  assign sec_n = {sech_q, secl_q} + {{(SEC_W-3){dsec[2]}}, dsec};

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0; frac_q <= '0; acc_q <= '0; ns_q <= '0;
      sech_q <= '0; secl_q <= '0; adj_pend <= 1'b0; adj_neg <= 1'b0;
      adj_mag <= '0; sh_ns <= '0; sh_sech <= '0;
    end else begin
      acc_q  <= w_ns   ? '0 : acc_sum[FRAC_W-1:0];
      ns_q   <= w_ns   ? wdata[NS_W-1:0] : t_norm[NS_W-1:0];
      sech_q <= w_sech ? wdata[SECH_W-1:0] : sec_n[SEC_W-1:32];
      secl_q <= w_secl ? wdata : sec_n[31:0];
      if (w_step) inc_q  <= wdata[INC_W-1:0];
      if (w_frac) frac_q <= wdata[FRAC_W-1:0];
      adj_pend <= w_adj;
      if (w_adj) begin
        adj_neg <= wdata[31];
        adj_mag <= wdata[NS_W-1:0];
      end
      if (rd_en && addr == A_SECL) begin
        sh_sech <= sech_q;
        sh_ns   <= ns_q;
      end
    end
  end

  always_comb begin
    case (addr)
      A_STEP:  rdata = 32'(inc_q);
      A_FRAC:  rdata = 32'(frac_q);
      A_SECH:  rdata = 32'(sh_sech);
      A_SECL:  rdata = secl_q;
      A_NS:    rdata = 32'(sh_ns);
      default: rdata = '0;
    endcase
  end

  wire unused_ok = ^{wdata, t_norm};
endmodule

module tod_counter_chk #(
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SECH_W = 16,
  parameter int NS_W   = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [31:0]       wdata,
  input logic [INC_W-1:0]  inc_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic [FRAC_W-1:0] acc_q,
  input logic [NS_W-1:0]   ns_q,
  input logic [NS_W-1:0]   sh_ns,
  input logic [SECH_W-1:0] sech_q,
  input logic [31:0]       secl_q,
  input logic              adj_pend
);
  assert_ns_range_R3: assert property (@(posedge clk) disable iff (rst)
    32'(ns_q) < NS_PER_SEC);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && inc_q == '0 && frac_q == '0 && !adj_pend)
    |=> ($stable(ns_q) && $stable(secl_q) && $stable(sech_q)));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !adj_pend)
    |=> ({sech_q, secl_q} == $past({sech_q, secl_q})
      || {sech_q, secl_q} == $past({sech_q, secl_q}) + 1'b1));

  assert_ns_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4) |=> (ns_q == $past(wdata[NS_W-1:0]) && acc_q == '0));

  assert_adj_once_R7: assert property (@(posedge clk) disable iff (rst)
    adj_pend && !(wr_en && addr == 3'd5) |=> !adj_pend);

  assert_snapshot_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd3) |=> sh_ns == $past(ns_q));
endmodule

bind tod_counter tod_counter_chk #(
  .INC_W(INC_W), .FRAC_W(FRAC_W), .SECH_W(SECH_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)
) chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .inc_q(inc_q), .frac_q(frac_q), .acc_q(acc_q), .ns_q(ns_q), .sh_ns(sh_ns),
  .sech_q(sech_q), .secl_q(secl_q), .adj_pend(adj_pend)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  localparam int PERIOD = 10;
  localparam longint NSPS = 1000000000;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;

  tod_counter uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int runs = 0, fails = 0;
  longint base_sec, base_ns, units, adj_tot, cur_u;
  int seg, cur_inc, cur_frac;
  logic [31:0] g_hi, g_lo, g_ns;
  int g_s;

  task automatic check(input string tag, input longint got, input longint exp);
    runs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic close_seg(input longint new_u);
    units += longint'(cyc - seg) * cur_u;
    seg = cyc;
    cur_u = new_u;
  endtask

  task automatic set_inc(input int i, input int f);
    wr(3'd0, 32'(i)); close_seg(longint'(i) * 65536 + cur_frac); cur_inc = i;
    wr(3'd1, 32'(f)); close_seg(longint'(cur_inc) * 65536 + f);  cur_frac = f;
  endtask

  task automatic set_time(input int hi, input longint lo, input int ns);
    wr(3'd4, 32'd0);
    wr(3'd2, 32'(hi));
    wr(3'd3, 32'(lo));
    wr(3'd4, 32'(ns));
    base_sec = (longint'(hi) << 32) | lo;
    base_ns = ns; units = 0; seg = cyc; adj_tot = 0;
  endtask

  task automatic offset(input logic [31:0] w);
    wr(3'd5, w);
    adj_tot += w[31] ? -longint'(w[29:0]) : longint'(w[29:0]);
  endtask

  task automatic snap();
    @(negedge clk); rd_en = 1'b1; addr = 3'd3; #1 g_lo = rdata; g_s = cyc;
    @(negedge clk); rd_en = 1'b0; addr = 3'd2; #1 g_hi = rdata;
    addr = 3'd4; #1 g_ns = rdata;
  endtask

  task automatic snap_check(input string tag);
    longint tot, q, r, es;
    snap();
    tot = base_ns + ((units + longint'(g_s - seg) * cur_u) >>> 16) + adj_tot;
    q = tot / NSPS; r = tot % NSPS;
    if (r < 0) begin r += NSPS; q -= 1; end
    es = base_sec + q;
    check({tag, " ns"}, longint'(g_ns), r);
    check({tag, " sec_lo"}, longint'(g_lo), es & 64'hFFFF_FFFF);
    check({tag, " sec_hi"}, longint'(g_hi), (es >> 32) & 64'hFFFF);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    int incs[5] = '{1, 2, 7, 40, 255};
    int fracs[5] = '{0, 1, 32768, 65535, 13107};
    base_sec = 0; base_ns = 0; units = 0; adj_tot = 0; cur_u = 0;
    cur_inc = 0; cur_frac = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seg = cyc;

    // R1 reset state and hold with zero increments
    snap_check("R1 reset");
    idle(10);
    snap_check("R1 hold");
    rd(3'd0, v); check("R1 step reset", v, 0);
    rd(3'd1, v); check("R1 frac reset", v, 0);

    // R2 sweep of step and fraction
    foreach (incs[i]) begin
      foreach (fracs[j]) begin
        set_inc(incs[i], fracs[j]);
        set_time(0, 1000, 5000);
        idle(incs[i] % 5 + fracs[j] % 7 + 2);
        snap_check("R2 sweep");
      end
    end

    // R10 readback
    set_inc(77, 4660);
    rd(3'd0, v); check("R10 step readback", v, 77);
    rd(3'd1, v); check("R10 frac readback", v, 4660);

    // R3 wrap with carry from lower into upper seconds
    set_inc(8, 16384);
    set_time(0, 64'hFFFF_FFFF, 999999950);
    idle(20);
    snap_check("R3 wrap carry");
    set_inc(255, 65535);
    set_time(3, 17, 999990000);
    idle(60);
    snap_check("R3 multi wrap");

    // R6 trimming mid-run, accumulator continues
    set_inc(10, 0);
    set_time(1, 5, 0);
    idle(5);
    set_inc(10, 32768);
    idle(7);
    set_inc(9, 65535);
    idle(3);
    snap_check("R6 trim");

    // R4 independent word writes
    set_inc(3, 0);
    set_time(0, 7, 0);
    idle(4);
    wr(3'd2, 32'h1234);
    base_sec = (longint'(16'h1234) << 32) | (base_sec & 64'hFFFF_FFFF);
    snap_check("R4 upper only");
    wr(3'd3, 32'h55);
    base_sec = (base_sec & 64'hFFFF_0000_0000) | 32'h55;
    snap_check("R4 lower only");

    // R5 nanosecond write clears accumulator (both parities)
    for (int k = 0; k < 2; k++) begin
      set_inc(1, 32768);
      set_time(0, 0, 0);
      idle(k);
      wr(3'd4, 32'd1000);
      base_ns = 1000; units = 0; seg = cyc;
      snap_check("R5 acc clear");
    end

    // R7 offsets with borrow and carry
    set_inc(10, 0);
    set_time(0, 100, 100);
    offset(32'h8000_0000 | 32'd500);
    snap_check("R7 borrow");
    set_time(0, 100, 999999000);
    offset(32'h3FFF_FFFF);
    snap_check("R7 carry two");
    set_time(0, 100, 50);
    offset(32'h8000_0000 | 32'h3FFF_FFFF);
    snap_check("R7 borrow two");
    set_time(2, 9, 400);
    offset(32'd123456);
    idle(3);
    snap_check("R7 once");

    // R8 zero offsets
    set_time(0, 40, 777);
    offset(32'h0000_0000);
    snap_check("R8 zero pos");
    offset(32'h8000_0000);
    snap_check("R8 zero neg");

    // R9 shadow held until next lower-word read
    set_inc(50, 0);
    set_time(0, 3, 0);
    snap_check("R9 snapshot");
    keep = g_ns;
    idle(6);
    rd(3'd4, v); check("R9 shadow held", v, keep);
    snap_check("R9 resnap");

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule